// File: doc/BRIEF.md
# UART Interrupt Cause Register

This block collects the interrupt sources of a serial port into one status word that a host reads over a simple register bus. Five cause bits are held independently, so several sources can be pending at once. These sources are line status, receive data, character timeout, transmit space and modem change. A cause bit that is zero means that source is idle. A status word whose cause field is all zero means nothing is pending.

The host clears causes in one of two ways. It can read the status word, which clears every cause as a side effect. It can also write a mask back to the lowest byte, which clears only the bits written as one. An event that lands in the same cycle as either kind of clear stays pending, so no interrupt is lost.

The same word carries a modem byte in bits 15:8. This byte holds the CTS and DCD levels and their change flags, uninverted. A configuration word at a second address holds the per-source enables and an automatic flow control switch. While automatic flow control is on, modem changes do not raise a cause.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the status word (address 0), the configuration word (address 1) and `irq` are all zero.
- R2: Status bits 4:0 are sticky cause flags, set by a one-cycle event and visible one cycle later. Bit 0 is line status, bit 1 is receive data, bit 2 is character timeout, bit 3 is transmit space and bit 4 is modem change. Any combination can be pending together, and each stays set until it is cleared.
- R3: A read strobe at address 0 clears all cause bits and both modem change flags on the following edge.
- R4: A write at address 0 with byte enable 0 set clears each cause bit whose matching write-data bit (4:0) is one. Cause bits whose write-data bit is zero are kept. Data bits 31:8 and writes without byte enable 0 change nothing.
- R5: A cause event in the same cycle as a destructive read or a write-clear leaves that cause bit set.
- R6: Status bits 15:8 form the modem byte. Bit 8 is the CTS level and bit 9 is the DCD level, both uninverted. Bit 10 is the CTS change flag and bit 11 is the DCD change flag, and bits 15:12 read zero. Each level is registered once. A level change sets its change flag and cause bit 4. The previous level after reset is taken as 0.
- R7: The configuration word at address 1 holds five bits, read back in bits 4:0, with higher bits reading zero. Bit 0 is the receive enable, which covers both receive data and timeout. Bit 1 is the transmit-space enable, bit 2 the line-status enable, bit 3 the modem enable and bit 4 automatic flow control.
- R8: `irq` is active high and equals the OR of the pending cause bits whose enable is set.
- R9: While automatic flow control is on, a modem level change does not set cause bit 4, but the change flags still latch.
- R10: Addresses 2 and 3 read as zero. Reads and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_line | input | 1 | Line-status event pulse |
| ev_rxdata | input | 1 | Receive-data event pulse |
| ev_timeout | input | 1 | Character timeout event pulse |
| ev_txspace | input | 1 | Transmit-space event pulse |
| cts_i | input | 1 | Synchronised CTS level |
| dcd_i | input | 1 | Synchronised DCD level |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe (destructive at address 0) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_rdata | output | DATA_W | Read data for the addressed word |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: a 32-bit data word and a 2-bit address. With these values the two unused addresses are reachable and can be shown to be inert. The 32-bit width also gives write data with ones above the cause field, which lets the bench show that these bits are ignored. A behavioural model runs next to the design on every cycle. Directed phases hit events that coincide with clears, modem changes under automatic flow control and each enable alone. A pseudo-random phase then mixes events, strobes and level changes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned CAUSE_W   = 5;
    localparam int unsigned C_LINE    = 0;
    localparam int unsigned C_RXDATA  = 1;
    localparam int unsigned C_TIMEOUT = 2;
    localparam int unsigned C_TXSPACE = 3;
    localparam int unsigned C_MODEM   = 4;

    localparam int unsigned CFG_W        = 5;
    localparam int unsigned CFG_RX_EN    = 0;
    localparam int unsigned CFG_TX_EN    = 1;
    localparam int unsigned CFG_LINE_EN  = 2;
    localparam int unsigned CFG_MODEM_EN = 3;
    localparam int unsigned CFG_AUTOFLOW = 4;

    localparam int unsigned MODEM_W = 4;

    typedef struct packed {
        logic ddcd;
        logic dcts;
        logic dcd;
        logic cts;
    } modem_state_t;

endpackage

// File: rtl/uart_irq_cause_bank.sv
module uart_irq_cause_bank #(
    parameter int unsigned CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_i,
    input  logic               clr_all_i,
    input  logic [CAUSE_W-1:0] clr_mask_i,
    output logic [CAUSE_W-1:0] pend_o
);

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_cell
        typedef struct packed {
            logic pend;
        } cell_t;

        cell_t cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (clr_all_i || clr_mask_i[i]) begin
                cell_d.pend = 1'b0;
            end
            if (ev_i[i]) begin
                cell_d.pend = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign pend_o[i] = cell_q.pend;
    end

endmodule

// File: rtl/uart_irq_modem_track.sv
module uart_irq_modem_track
    import uart_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cts_i,
    input  logic         dcd_i,
    input  logic         clr_delta_i,
    output modem_state_t state_o,
    output logic         change_o
);

    modem_state_t st_d, st_q;
    logic         cts_chg, dcd_chg;

    always_comb begin
        cts_chg   = cts_i ^ st_q.cts;
        dcd_chg   = dcd_i ^ st_q.dcd;
        st_d      = st_q;
        st_d.cts  = cts_i;
        st_d.dcd  = dcd_i;
        st_d.dcts = (st_q.dcts & ~clr_delta_i) | cts_chg;
        st_d.ddcd = (st_q.ddcd & ~clr_delta_i) | dcd_chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o  = st_q;
    assign change_o = cts_chg | dcd_chg;

endmodule

// File: rtl/uart_irq_cfg_reg.sv
module uart_irq_cfg_reg #(
    parameter int unsigned CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o
);

    typedef struct packed {
        logic [CFG_W-1:0] bits;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.bits = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q.bits;

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned STATUS_ADDR = 0,
    parameter int unsigned CONFIG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_line,
    input  logic              ev_rxdata,
    input  logic              ev_timeout,
    input  logic              ev_txspace,
    input  logic              cts_i,
    input  logic              dcd_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W/8-1:0] bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned BE_W    = DATA_W / 8;
    localparam int unsigned MSR_LSB = 8;

    logic               sel_status, sel_config;
    logic               clr_all;
    logic [CAUSE_W-1:0] clr_mask;
    logic               wr_cfg;
    logic [CAUSE_W-1:0] ev_vec;
    logic [CAUSE_W-1:0] pend_q;
    logic [CAUSE_W-1:0] enable;
    logic [CFG_W-1:0]   cfg_q;
    modem_state_t       modem;
    logic               modem_chg;
    logic               unused_bus_bits;

    assign sel_status = (bus_addr == ADDR_W'(STATUS_ADDR));
    assign sel_config = (bus_addr == ADDR_W'(CONFIG_ADDR));
    assign clr_all    = bus_rd & sel_status;
    assign clr_mask   = (bus_wr && sel_status && bus_be[0]) ? bus_wdata[CAUSE_W-1:0] : '0;
    assign wr_cfg     = bus_wr & sel_config;

    assign unused_bus_bits = ^{bus_wdata[DATA_W-1:CFG_W], bus_be[BE_W-1:1]};

    always_comb begin
        ev_vec            = '0;
        ev_vec[C_LINE]    = ev_line;
        ev_vec[C_RXDATA]  = ev_rxdata;
        ev_vec[C_TIMEOUT] = ev_timeout;
        ev_vec[C_TXSPACE] = ev_txspace;
        ev_vec[C_MODEM]   = modem_chg & ~cfg_q[CFG_AUTOFLOW];
    end

    always_comb begin
        enable            = '0;
        enable[C_LINE]    = cfg_q[CFG_LINE_EN];
        enable[C_RXDATA]  = cfg_q[CFG_RX_EN];
        enable[C_TIMEOUT] = cfg_q[CFG_RX_EN];
        enable[C_TXSPACE] = cfg_q[CFG_TX_EN];
        enable[C_MODEM]   = cfg_q[CFG_MODEM_EN];
    end

    uart_irq_cause_bank #(
        .CAUSE_W (CAUSE_W)
    ) u_causes (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_vec),
        .clr_all_i  (clr_all),
        .clr_mask_i (clr_mask),
        .pend_o     (pend_q)
    );

    uart_irq_modem_track u_modem (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_i       (cts_i),
        .dcd_i       (dcd_i),
        .clr_delta_i (clr_all),
        .state_o     (modem),
        .change_o    (modem_chg)
    );

    uart_irq_cfg_reg #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cfg),
        .wdata_i (bus_wdata[CFG_W-1:0]),
        .cfg_o   (cfg_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_status) begin
            bus_rdata[CAUSE_W-1:0]         = pend_q;
            bus_rdata[MSR_LSB +: MODEM_W]  = modem;
        end else if (sel_config) begin
            bus_rdata[CFG_W-1:0] = cfg_q;
        end
    end

    assign irq = |(pend_q & enable);

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
    parameter int unsigned CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq,
    input logic               clr_all,
    input logic [CAUSE_W-1:0] clr_mask,
    input logic [CAUSE_W-1:0] ev_vec,
    input logic [CAUSE_W-1:0] pend,
    input logic               autoflow
);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && clr_mask == '0) |=> ((pend & $past(pend)) == $past(pend)));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && ev_vec == '0) |=> (pend == '0));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && clr_mask != '0) |=> ((pend & $past(clr_mask & ~ev_vec)) == '0));

    assert_event_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec != '0) |=> ((pend & $past(ev_vec)) == $past(ev_vec)));

    assert_irq_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));

    assert_autoflow_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (autoflow && !pend[CAUSE_W-1]) |=> !pend[CAUSE_W-1]);

endmodule

bind uart_irq_status uart_irq_status_chk #(
    .CAUSE_W (uart_irq_pkg::CAUSE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .clr_all  (clr_all),
    .clr_mask (clr_mask),
    .ev_vec   (ev_vec),
    .pend     (pend_q),
    .autoflow (cfg_q[uart_irq_pkg::CFG_AUTOFLOW])
);

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_line = 0, ev_rxdata = 0, ev_timeout = 0, ev_txspace = 0;
    logic        cts_i = 0, dcd_i = 0;
    logic [1:0]  bus_addr = 2'd2;
    logic        bus_rd = 0, bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [4:0] m_cause = '0;
    logic [4:0] m_cfg   = '0;
    logic       m_cts = 0, m_dcd = 0, m_dcts = 0, m_ddcd = 0;

    always #10 clk = ~clk;

    uart_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .ev_line(ev_line), .ev_rxdata(ev_rxdata), .ev_timeout(ev_timeout),
        .ev_txspace(ev_txspace), .cts_i(cts_i), .dcd_i(dcd_i),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rdata();
        if (bus_addr == 2'd0)
            return {16'h0, 4'h0, m_ddcd, m_dcts, m_dcd, m_cts, 3'b000, m_cause};
        else if (bus_addr == 2'd1)
            return {27'h0, m_cfg};
        return 32'h0;
    endfunction

    function automatic logic exp_irq();
        logic [4:0] en;
        en = {m_cfg[3], m_cfg[1], m_cfg[0], m_cfg[0], m_cfg[2]};
        return |(m_cause & en);
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (bus_rdata !== exp_rdata()) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, bus_addr, bus_rdata, exp_rdata());
        end
        n_cmp++;
        if (irq !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq());
        end
    endtask

    task automatic model_update();
        logic       clr_rd, chg_c, chg_d;
        logic [4:0] wmask, ev;
        clr_rd = bus_rd && bus_addr == 2'd0;
        wmask  = (bus_wr && bus_addr == 2'd0 && bus_be[0]) ? bus_wdata[4:0] : 5'h0;
        chg_c  = cts_i != m_cts;
        chg_d  = dcd_i != m_dcd;
        ev     = {(chg_c | chg_d) & ~m_cfg[4], ev_txspace, ev_timeout, ev_rxdata, ev_line};
        m_cause = (m_cause & ~(clr_rd ? 5'h1F : wmask)) | ev;
        m_dcts  = (m_dcts & ~clr_rd) | chg_c;
        m_ddcd  = (m_ddcd & ~clr_rd) | chg_d;
        m_cts   = cts_i;
        m_dcd   = dcd_i;
        if (bus_wr && bus_addr == 2'd1) m_cfg = bus_wdata[4:0];
    endtask

    // called at a falling edge with inputs already set
    task automatic step(input string tag);
        #2 compare(tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle(input logic [1:0] a);
        ev_line = 0; ev_rxdata = 0; ev_timeout = 0; ev_txspace = 0;
        bus_rd = 0; bus_wr = 0; bus_wdata = '0; bus_be = '0; bus_addr = a;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        idle(2'd0); step("R1");
        idle(2'd1); step("R1");

        // R2 several causes together, sticky
        idle(2'd2); ev_line = 1; ev_timeout = 1; step("R2");
        idle(2'd0); step("R2");
        idle(2'd0); ev_rxdata = 1; ev_txspace = 1; step("R2");
        idle(2'd0); step("R2");
        idle(2'd0); step("R2");

        // R3 destructive read
        idle(2'd0); bus_rd = 1; step("R3");
        idle(2'd0); step("R3");

        // R4 write-one-to-clear
        idle(2'd2); {ev_line, ev_rxdata, ev_timeout, ev_txspace} = 4'hF; step("R4");
        idle(2'd0); bus_wr = 1; bus_be = 4'h1; bus_wdata = 32'h0000_000A; step("R4");
        idle(2'd0); step("R4");
        idle(2'd0); bus_wr = 1; bus_be = 4'hE; bus_wdata = 32'h0000_001F; step("R4");
        idle(2'd0); bus_wr = 1; bus_be = 4'hF; bus_wdata = 32'hFFFF_FF00; step("R4");
        idle(2'd0); step("R4");

        // R5 events coinciding with clears
        idle(2'd0); bus_rd = 1; ev_rxdata = 1; step("R5");
        idle(2'd0); step("R5");
        idle(2'd0); bus_wr = 1; bus_be = 4'h1; bus_wdata = 32'h0000_001F; ev_line = 1; step("R5");
        idle(2'd0); step("R5");
        idle(2'd0); bus_rd = 1; step("R5");

        // R6 modem byte
        idle(2'd0); cts_i = 1; step("R6");
        idle(2'd0); step("R6");
        idle(2'd0); dcd_i = 1; bus_rd = 1; step("R6");
        idle(2'd0); step("R6");
        idle(2'd0); bus_rd = 1; step("R6");
        idle(2'd0); cts_i = 0; step("R6");
        idle(2'd0); bus_rd = 1; step("R6");

        // R7 configuration word
        idle(2'd1); bus_wr = 1; bus_wdata = 32'hFFFF_FFFF; step("R7");
        idle(2'd1); step("R7");
        idle(2'd1); bus_wr = 1; bus_wdata = 32'h0000_0000; step("R7");

        // R8 each enable alone
        for (int b = 0; b < 4; b++) begin
            idle(2'd2); {ev_txspace, ev_timeout, ev_rxdata, ev_line} = 4'hF; step("R8");
            idle(2'd1); bus_wr = 1; bus_wdata = 32'(1 << b); step("R8");
            idle(2'd1); step("R8");
            idle(2'd0); bus_rd = 1; step("R8");
            idle(2'd1); step("R8");
        end
        idle(2'd1); bus_wr = 1; bus_wdata = 32'h0000_0008; step("R8");
        idle(2'd0); dcd_i = 0; step("R8");
        idle(2'd0); bus_rd = 1; step("R8");
        idle(2'd0); step("R8");

        // R9 automatic flow control suppresses modem cause
        idle(2'd1); bus_wr = 1; bus_wdata = 32'h0000_0018; step("R9");
        idle(2'd0); cts_i = 1; step("R9");
        idle(2'd0); step("R9");
        idle(2'd0); dcd_i = 1; bus_rd = 1; step("R9");
        idle(2'd0); step("R9");
        idle(2'd1); bus_wr = 1; bus_wdata = 32'h0000_0008; step("R9");
        idle(2'd0); cts_i = 0; step("R9");
        idle(2'd0); step("R9");

        // R10 unused addresses
        idle(2'd2); bus_wr = 1; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF; step("R10");
        idle(2'd3); bus_wr = 1; bus_be = 4'hF; bus_wdata = 32'hFFFF_FFFF; bus_rd = 1; step("R10");
        idle(2'd2); bus_rd = 1; step("R10");
        idle(2'd0); step("R10");
        idle(2'd1); step("R10");

        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            idle(r[1:0]);
            ev_line    = r[2] & r[3];
            ev_rxdata  = r[4] & r[5];
            ev_timeout = r[6] & r[7];
            ev_txspace = r[8] & r[9];
            bus_rd     = r[10] & r[11];
            bus_wr     = r[12] & r[13] & r[14];
            bus_be     = r[18:15];
            bus_wdata  = {r[31:19], r[12:0], r[31:26]};
            if (r[20] & r[21] & r[22]) cts_i = ~cts_i;
            if (r[23] & r[24] & r[25]) dcd_i = ~dcd_i;
            step("R2");
        end

        done = 1;
        summary();
    end

endmodule